// File: doc/BRIEF.md
# Time-Shared Quadrature Oscillator Table Reader

This block turns a pair of quarter-wave table indices, one for the cosine term and one for the sine term, plus a negate flag for each, into a signed in-phase/quadrature oscillator sample. It sits behind an angle-folding stage in a numerically controlled oscillator. The folding stage has already reduced the phase to the first quadrant and worked out the signs. This block does the phase-to-amplitude lookup for both components with a single table port.

The table holds only non-negative first-quadrant cosine words. It is read on a clock running at twice the sample rate, once for each index inside every sample period. The first word read is held back by one register. Two registers with clock enables then split the two words onto separate I and Q paths, and the requested signs are applied by two's-complement negation. A final pair of registers clocked by the sample clock hands the I/Q pair to the sample-rate logic downstream. Both clocks come from one source and their rising edges are aligned. Every rising edge of `clk_1x` coincides with a rising edge of `clk_2x`.

Top module: `quad_lut_reader`

## Requirements
- R1: When `rst_n` is low at a `clk_1x` rising edge, both outputs are zero after that edge. If `rst_n` was low for at least two `clk_1x` edges, the outputs are still zero after the first `clk_1x` rising edge following release.
- R2: Table word k equals round(A·cos(2πk/(4·D))), clamped to A. Here A = 2^(DATA_W-1)-1 and D = 2^ADDR_W. With `cos_neg` = 0, `i_out` equals the word at `cos_idx`, as a signed two's-complement value with DATA_W-1 fraction bits.
- R3: `q_out` comes from the word at `sin_idx` and `i_out` from the word at `cos_idx`, including when both indices are equal. The cosine word is read in the first `clk_2x` cycle of each sample period and the sine word in the second.
- R4: A negate flag of 1 turns its component into the two's-complement negative of the table word. A flag of 0 leaves it positive. `cos_neg` acts only on `i_out` and `sin_neg` only on `q_out`, and any nonzero output carries the sign its flag requested.
- R5: Inputs launched at `clk_1x` rising edge n and held for that period appear on the outputs right after `clk_1x` rising edge n+2. A new I/Q pair follows every sample period.
- R6: The outputs change only at `clk_1x` rising edges. They hold their value across the intermediate `clk_2x` rising edge.
- R7: Neither output ever takes the most negative code, -2^(DATA_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Table clock at twice the sample rate, rising edges aligned with clk_1x |
| clk_1x | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clock domains |
| cos_idx | input | ADDR_W | Quarter-table index for the in-phase term, held for one sample period |
| sin_idx | input | ADDR_W | Quarter-table index for the quadrature term, held for one sample period |
| cos_neg | input | 1 | 1 negates the in-phase output |
| sin_neg | input | 1 | 1 negates the quadrature output |
| i_out | output | DATA_W | Signed in-phase sample |
| q_out | output | DATA_W | Signed quadrature sample |

## Verification
The first sweep walks every table address on the cosine index while the sine index runs the mirrored address. The two components then almost never share a value, so a swapped slot or a mis-steered enable shows up as a wrong value on both outputs. The two low index bits drive the negate flags independently, which exposes a flag applied to the wrong path or not applied at all. A second sweep gives both indices the same address with mixed signs, so the steering can only be judged through the signs. Each output is sampled just after a `clk_1x` edge and again after the intermediate `clk_2x` edge. This checks the two-period latency and shows whether any value leaks out between sample edges.

// File: rtl/qlr_pkg.sv
// Package for the quadrature table reader.
// Holds the slot encoding shared by the slot generator and the steering
// logic, and the function that computes one quarter-cosine table word.
package qlr_pkg;

    // Which table read is on the address bus in the current clk_2x cycle.
    typedef enum logic {
        SLOT_SIN = 1'b0,
        SLOT_COS = 1'b1
    } slot_e;

    localparam real TWO_PI = 6.283185307179586;

    // Word k of a quarter-wave cosine table with depth entries, scaled to amp.
    // The result is rounded to nearest and clamped to [0, amp].
    function automatic int quarter_cos_word(input int k, input int depth, input int amp);
        real x;
        int  r;
        x = real'(amp) * $cos(TWO_PI * real'(k) / (4.0 * real'(depth)));
        r = $rtoi(x + 0.5);
        if (r > amp) r = amp;
        if (r < 0)   r = 0;
        return r;
    endfunction

endpackage

// File: rtl/qlr_slot_gen.sv
// Slot generator.
// Produces the clk_2x-domain slot indicator: SLOT_COS in the first clk_2x
// cycle of each sample period, SLOT_SIN in the second.
// Assumes clk_1x rising edges coincide with clk_2x rising edges.
// A toggle flips on every clk_1x edge; a clk_2x copy of it lags by one fast
// cycle, so the two differ exactly in the first half of the period.
module qlr_slot_gen
    import qlr_pkg::*;
(
    input  logic  clk_1x,
    input  logic  clk_2x,
    input  logic  rst_n,
    output slot_e slot
);

    logic tog_slow;
    logic tog_seen;

    // Sample-rate toggle marking each new sample period.
    always_ff @(posedge clk_1x) begin
        if (!rst_n) tog_slow <= 1'b0;
        else        tog_slow <= ~tog_slow;
    end

    // Fast-domain copy of the toggle, one clk_2x cycle behind.
    always_ff @(posedge clk_2x) begin
        if (!rst_n) tog_seen <= 1'b0;
        else        tog_seen <= tog_slow;
    end

    // Slot decode: a mismatch means the period has just started.
    always_comb begin
        slot = (tog_slow != tog_seen) ? SLOT_COS : SLOT_SIN;
    end

    AST_SLOT_ALTERNATE: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (slot == SLOT_COS) |=> (slot == SLOT_SIN)); // R3

endmodule

// File: rtl/qlr_quarter_rom.sv
// Quarter-wave cosine table with one synchronous read port.
// Holds non-negative first-quadrant cosine words, computed when the model is
// elaborated. The address is registered on every clk_2x edge; the word
// appears one fast cycle after its address was presented.
module qlr_quarter_rom
    import qlr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 12
) (
    input  logic              clk_2x,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int AMP   = (1 << (DATA_W - 1)) - 1;

    logic [DATA_W-1:0] table_mem [DEPTH];

    // Table contents: one computed word per quarter-wave address.
    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            table_mem[k] = DATA_W'(quarter_cos_word(k, DEPTH, AMP));
        end
    end

    // Registered read port shared by both quadrature components.
    always_ff @(posedge clk_2x) begin
        if (!rst_n) word <= '0;
        else        word <= table_mem[addr];
    end

endmodule

// File: rtl/qlr_steer.sv
// Demultiplexer and sign stage.
// Takes the two table words that share one read port, holds the cosine
// word back by one register, then captures both words together onto the I
// and Q paths, negating each one on request.
// Assumes the cosine word is on rom_word during the SLOT_SIN cycle and the
// sine word during the SLOT_COS cycle that follows it.
module qlr_steer
    import qlr_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk_2x,
    input  logic              rst_n,
    input  slot_e             slot,
    input  logic [DATA_W-1:0] rom_word,
    input  logic              cos_neg,
    input  logic              sin_neg,
    output logic [DATA_W-1:0] i_word,
    output logic [DATA_W-1:0] q_word
);

    logic [DATA_W-1:0] cos_hold;
    logic              neg_i;
    logic              neg_q;

    // Delay register: keeps the cosine word while the sine word is read.
    always_ff @(posedge clk_2x) begin
        if (!rst_n)                cos_hold <= '0;
        else if (slot == SLOT_SIN) cos_hold <= rom_word;
    end

    // Enable-gated capture of both paths with two's-complement negation.
    always_ff @(posedge clk_2x) begin
        if (!rst_n) begin
            i_word <= '0;
            q_word <= '0;
        end else if (slot == SLOT_COS) begin
            i_word <= neg_i ? -cos_hold : cos_hold;
            q_word <= neg_q ? -rom_word : rom_word;
        end
    end

    // Sign flags of the current period, taken while the indices are valid.
    always_ff @(posedge clk_2x) begin
        if (!rst_n) begin
            neg_i <= 1'b0;
            neg_q <= 1'b0;
        end else if (slot == SLOT_COS) begin
            neg_i <= cos_neg;
            neg_q <= sin_neg;
        end
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk_2x) disable iff (!rst_n)
        (slot == SLOT_SIN) |=> ($stable(i_word) && $stable(q_word))); // R6

endmodule

// File: rtl/qlr_retime.sv
// Sample-clock output registers.
// Moves the I/Q pair from the clk_2x paths into the clk_1x domain.
// Assumes the inputs change only at the intermediate clk_2x edge, so they
// are settled at every clk_1x rising edge.
module qlr_retime #(
    parameter int DATA_W = 12
) (
    input  logic                     clk_1x,
    input  logic                     rst_n,
    input  logic        [DATA_W-1:0] i_word,
    input  logic        [DATA_W-1:0] q_word,
    output logic signed [DATA_W-1:0] i_out,
    output logic signed [DATA_W-1:0] q_out
);

    // Output pair registered on the sample clock.
    always_ff @(posedge clk_1x) begin
        if (!rst_n) begin
            i_out <= '0;
            q_out <= '0;
        end else begin
            i_out <= i_word;
            q_out <= q_word;
        end
    end

endmodule

// File: rtl/quad_lut_reader.sv
// Time-shared quadrature table reader, top level.
// One quarter-cosine table port at twice the sample rate serves both the
// in-phase and quadrature lookups. The address mux picks the cosine index
// in the first fast cycle and the sine index in the second.
// Assumes: clk_1x and clk_2x come from one source with aligned rising edges;
// the indices and negate flags are launched at a clk_1x edge and held for
// the whole period. Latency: inputs launched at clk_1x edge n reach the
// outputs at edge n+2.
module quad_lut_reader
    import qlr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 12
) (
    input  logic                     clk_2x,
    input  logic                     clk_1x,
    input  logic                     rst_n,
    input  logic        [ADDR_W-1:0] cos_idx,
    input  logic        [ADDR_W-1:0] sin_idx,
    input  logic                     cos_neg,
    input  logic                     sin_neg,
    output logic signed [DATA_W-1:0] i_out,
    output logic signed [DATA_W-1:0] q_out
);

    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W - 1){1'b0}}};

    slot_e             slot;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rom_word;
    logic [DATA_W-1:0] i_word;
    logic [DATA_W-1:0] q_word;

    qlr_slot_gen u_slot (
        .clk_1x (clk_1x),
        .clk_2x (clk_2x),
        .rst_n  (rst_n),
        .slot   (slot)
    );

    // Address mux: cosine index first, sine index second.
    always_comb begin
        rd_addr = (slot == SLOT_COS) ? cos_idx : sin_idx;
    end

    qlr_quarter_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rom (
        .clk_2x (clk_2x),
        .rst_n  (rst_n),
        .addr   (rd_addr),
        .word   (rom_word)
    );

    qlr_steer #(
        .DATA_W (DATA_W)
    ) u_steer (
        .clk_2x   (clk_2x),
        .rst_n    (rst_n),
        .slot     (slot),
        .rom_word (rom_word),
        .cos_neg  (cos_neg),
        .sin_neg  (sin_neg),
        .i_word   (i_word),
        .q_word   (q_word)
    );

    qlr_retime #(
        .DATA_W (DATA_W)
    ) u_retime (
        .clk_1x (clk_1x),
        .rst_n  (rst_n),
        .i_word (i_word),
        .q_word (q_word),
        .i_out  (i_out),
        .q_out  (q_out)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk_1x) disable iff (!rst_n)
        !$past(rst_n) |-> (i_out == '0 && q_out == '0)); // R1

    AST_I_SIGN: assert property (@(posedge clk_1x) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && i_out != '0)
        |-> (i_out[DATA_W-1] == $past(cos_neg, 2))); // R4

    AST_Q_SIGN: assert property (@(posedge clk_1x) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) && q_out != '0)
        |-> (q_out[DATA_W-1] == $past(sin_neg, 2))); // R4

    AST_NO_MOST_NEG: assert property (@(posedge clk_1x) disable iff (!rst_n)
        (i_out != MOST_NEG) && (q_out != MOST_NEG)); // R7

endmodule

// File: tb/tb_quad_lut_reader.sv
`timescale 1ns/1ps
module tb_quad_lut_reader;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 12;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int AMP    = (1 << (DATA_W - 1)) - 1;
    localparam int STEPS  = 2 * DEPTH + 2;

    logic                     clk_2x;
    logic                     clk_1x;
    logic                     rst_n;
    logic        [ADDR_W-1:0] cos_idx;
    logic        [ADDR_W-1:0] sin_idx;
    logic                     cos_neg;
    logic                     sin_neg;
    logic signed [DATA_W-1:0] i_out;
    logic signed [DATA_W-1:0] q_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    quad_lut_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk_2x (clk_2x),
        .clk_1x (clk_1x),
        .rst_n  (rst_n),
        .cos_idx(cos_idx),
        .sin_idx(sin_idx),
        .cos_neg(cos_neg),
        .sin_neg(sin_neg),
        .i_out  (i_out),
        .q_out  (q_out)
    );

    // 250 MHz table clock; the sample clock rises on every other fast edge.
    initial begin
        clk_2x = 1'b0;
        clk_1x = 1'b0;
        forever begin
            #2;
            clk_2x = 1'b1;
            clk_1x = ~clk_1x;
            #2;
            clk_2x = 1'b0;
        end
    end

    // Expected table word from the R2 formula.
    function automatic int entry(input int k);
        real x;
        int  r;
        x = real'(AMP) * $cos(6.283185307179586 * real'(k) / (4.0 * real'(DEPTH)));
        r = $rtoi(x + 0.5);
        if (r > AMP) r = AMP;
        return r;
    endfunction

    // Stimulus for step j: mirrored sweep, then equal-index sweep, then idle.
    function automatic void vec(input int j, output int c, output int s,
                                output bit cn, output bit sn);
        int k;
        if (j < DEPTH) begin
            c = j; s = DEPTH - 1 - j; cn = j[0]; sn = j[1];
        end else if (j < 2 * DEPTH) begin
            k = j - DEPTH;
            c = k; s = k; cn = k[1] ^ k[0]; sn = k[0];
        end else begin
            c = 0; s = 0; cn = 1'b0; sn = 1'b0;
        end
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        rst_n   = 1'b0;
        cos_idx = '0;
        sin_idx = '0;
        cos_neg = 1'b0;
        sin_neg = 1'b0;
        repeat (4) @(posedge clk_1x);
        #1;
        check_eq("R1 i_out in reset", int'(i_out), 0);
        check_eq("R1 q_out in reset", int'(q_out), 0);
        rst_n = 1'b1;

        for (int j = 0; j < STEPS; j++) begin
            int c, s, ei, eq, hold_i, hold_q;
            bit cn, sn;
            @(posedge clk_1x);
            #1;
            hold_i = int'(i_out);
            hold_q = int'(q_out);
            if (j == 0) begin
                check_eq("R1 i_out first edge after release", hold_i, 0);
                check_eq("R1 q_out first edge after release", hold_q, 0);
            end else if (j >= 2) begin
                // R5: output after this edge reflects the vector of step j-2
                vec(j - 2, c, s, cn, sn);
                ei = cn ? -entry(c) : entry(c);
                eq = sn ? -entry(s) : entry(s);
                if (cn) check_eq("R4/R5 negated i_out", hold_i, ei);
                else    check_eq("R2/R5 i_out table word", hold_i, ei);
                if (sn) check_eq("R4/R5 negated q_out", hold_q, eq);
                else    check_eq("R3/R5 q_out table word", hold_q, eq);
            end
            n_checks++;
            if (hold_i == -(AMP + 1) || hold_q == -(AMP + 1)) begin
                n_fail++;
                $display("FAIL R7 most negative code: actual i=%0d q=%0d expected above %0d",
                         hold_i, hold_q, -(AMP + 1));
            end
            vec(j, c, s, cn, sn);
            cos_idx = ADDR_W'(c);
            sin_idx = ADDR_W'(s);
            cos_neg = cn;
            sin_neg = sn;
            #4;
            check_eq("R6 i_out held across fast edge", int'(i_out), hold_i);
            check_eq("R6 q_out held across fast edge", int'(q_out), hold_q);
        end

        // Reset in the middle of operation.
        cos_idx = ADDR_W'(DEPTH / 3);
        sin_idx = ADDR_W'(DEPTH / 5);
        @(posedge clk_1x);
        #1;
        rst_n = 1'b0;
        repeat (2) begin
            @(posedge clk_1x);
            #1;
            check_eq("R1 i_out mid-run reset", int'(i_out), 0);
            check_eq("R1 q_out mid-run reset", int'(q_out), 0);
        end
        rst_n = 1'b1;
        @(posedge clk_1x);
        #1;
        check_eq("R1 i_out after mid-run release", int'(i_out), 0);
        check_eq("R1 q_out after mid-run release", int'(q_out), 0);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk_2x);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule